// File: doc/BRIEF.md
# Rolling Shutter Row Sequencer

This block paces a rolling-shutter pixel array one row period at a time. Each frame has a fixed number of row slots. The read pointer takes one window row per slot, in ascending order, starting at the top of the frame. The slots left over after the last window row are vertical blanking. A second pointer resets the same rows in the same order, a fixed number of slots earlier. The distance between the two pointers is the exposure, and the pointer spacing makes it identical for every row of a frame. A frame-start pulse marks the slot in which the top window row is read.

The exposure, in row periods, comes in through a configuration write strobe and is held in a shadow register. The shadow is copied into the active value only when the read pointer wraps to a new frame. The active value decides when the reset sweep for the next frame begins, so the frame being read never sees the change. The adopted value is clamped to the range 1 to frame length minus one. A rise is also limited to the blanking slack (frame length minus window height) per frame, so two reset sweeps never overlap. A long step up is therefore reached over several frames, and each of those frames is uniform.

After reset, the sequencer is controlled by three states:
- `SEQ_IDLE`: waits for the first row tick.
- `SEQ_PRIME`: one priming frame in which only resets run.
- `SEQ_STREAM`: reads, resets and frame-start pulses run continuously.

The transitions are:
- IDLE→PRIME: on the first row tick. This is also the first adoption of the exposure.
- PRIME→STREAM: at the end of the last slot of the priming frame.
- STREAM→STREAM: at every frame wrap.
- Any state→IDLE: when reset is asserted.

The window bounds and frame length are treated as static while running. They must satisfy win_last ≥ win_first and frame_len ≥ window height ≥ 1, with frame_len ≥ 2.

Top module: `rolling_row_seq`

## Requirements
- R1: While rst_n is low, and during the first row period after release, rst_vld, rd_vld and frame_start are 0. No read is issued during the priming frame (the first frame_len slots).
- R2: Outputs change only at row boundaries, which occur every ROW_CLKS clocks. All outputs are held for the whole row period.
- R3: In streaming, slot s (0 ≤ s < frame_len) of each frame reads row win_first+s with rd_vld=1 when s < H, where H = win_last−win_first+1. rd_vld is 0 in the remaining slots. Every frame lasts exactly frame_len slots.
- R4: frame_start is 1 exactly in slot 0 of each streaming frame, together with the read of row win_first.
- R5: With adopted exposure E, the reset sweep for the next frame starts in slot frame_len−E of the current read frame. It resets rows win_first..win_last in order, one per slot, and may run on into the next frame.
- R6: Every row is read exactly E slots after its reset, with the same E for all rows of a frame.
- R7: A value written with cfg_wr goes to the shadow register only. It is adopted at the next read-frame wrap and first applies to the frame after that; the frame in progress keeps its exposure.
- R8: The adopted exposure is clamped to at least 1 and at most frame_len−1.
- R9: From one adoption to the next, the exposure rises by at most frame_len−H.
- R10: A row is never reset and read in the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_first | input | ROW_W | First row of the window |
| win_last | input | ROW_W | Last row of the window |
| frame_len | input | ROW_W+1 | Frame length in row slots |
| cfg_wr | input | 1 | Configuration write strobe for the exposure |
| cfg_integ | input | ROW_W+1 | Exposure value, in row periods, to write |
| rst_row | output | ROW_W | Row being reset |
| rst_vld | output | 1 | rst_row is valid this row period |
| rd_row | output | ROW_W | Row being read |
| rd_vld | output | 1 | rd_row is valid this row period |
| frame_start | output | 1 | High for the row period in which the first window row is read |

## Verification
Some behaviours are checked by the assertions on every clock:
- both pointers stay inside the window and step by one row;
- frame_start coincides with a read of the top row;
- reset and read never hit the same row together;
- outputs are quiet under reset.

Other behaviours can only be shown by the bench's scenarios, because they depend on the history of writes and frame wraps:
- the exact slot in which a reset sweep begins;
- the uniform reset-to-read spacing per frame;
- the one-frame delay before a written exposure takes effect;
- clamping, and the per-frame limit on an exposure rise.

// File: rtl/rolling_row_seq_pkg.sv
`timescale 1ns/1ps
package rolling_row_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_PRIME  = 2'd1,
        SEQ_STREAM = 2'd2
    } seq_state_t;
endpackage

// File: rtl/rrs_row_timer.sv
`timescale 1ns/1ps
module rrs_row_timer #(
    parameter int ROW_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic row_tick
);
    localparam int CW = (ROW_CLKS > 1) ? $clog2(ROW_CLKS) : 1;

    generate
        if (ROW_CLKS == 1) begin : g_every
            assign row_tick = 1'b1;
        end else begin : g_count
            logic [CW-1:0] cnt_q;
            assign row_tick = (cnt_q == CW'(ROW_CLKS - 1));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        cnt_q <= '0;
                else if (row_tick) cnt_q <= '0;
                else               cnt_q <= cnt_q + CW'(1);
            end
        end
    endgenerate
endmodule

// File: rtl/rrs_integ_ctrl.sv
`timescale 1ns/1ps
module rrs_integ_ctrl #(
    parameter int FL_W      = 12,
    parameter int INTEG_RST = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [FL_W-1:0] cfg_integ,
    input  logic [FL_W-1:0] frame_len,
    input  logic [FL_W-1:0] win_rows,
    input  logic            adopt,
    input  logic            first_adopt,
    output logic [FL_W-1:0] integ_act
);
    logic [FL_W-1:0] shadow_q;
    logic [FL_W-1:0] lo_fix;
    logic [FL_W-1:0] hi_lim;
    logic [FL_W-1:0] full_clamp;
    logic [FL_W:0]   rise_cap;
    logic [FL_W-1:0] chosen;

    always_comb begin
        lo_fix     = (shadow_q == '0) ? FL_W'(1) : shadow_q;
        hi_lim     = frame_len - FL_W'(1);
        full_clamp = (lo_fix > hi_lim) ? hi_lim : lo_fix;
        rise_cap   = {1'b0, integ_act} + {1'b0, frame_len} - {1'b0, win_rows};
        if (!first_adopt && ({1'b0, full_clamp} > rise_cap))
            chosen = rise_cap[FL_W-1:0];
        else
            chosen = full_clamp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q  <= FL_W'(INTEG_RST);
            integ_act <= FL_W'(1);
        end else begin
            if (cfg_wr) shadow_q  <= cfg_integ;
            if (adopt)  integ_act <= chosen;
        end
    end
endmodule

// File: rtl/rolling_row_seq.sv
`timescale 1ns/1ps
module rolling_row_seq
    import rolling_row_seq_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int ROW_CLKS  = 4,
    parameter int INTEG_RST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] win_first,
    input  logic [ROW_W-1:0] win_last,
    input  logic [ROW_W:0]   frame_len,
    input  logic             cfg_wr,
    input  logic [ROW_W:0]   cfg_integ,
    output logic [ROW_W-1:0] rst_row,
    output logic             rst_vld,
    output logic [ROW_W-1:0] rd_row,
    output logic             rd_vld,
    output logic             frame_start
);
    localparam int FL_W = ROW_W + 1;

    seq_state_t      state_q, state_d;
    logic            row_tick;
    logic [FL_W-1:0] rd_slot_q;
    logic [FL_W-1:0] rst_idx_q;
    logic            rst_busy_q;
    logic [FL_W-1:0] win_rows;
    logic [FL_W-1:0] next_slot;
    logic [FL_W-1:0] integ_act;
    logic            slot_last;
    logic            adopt;
    logic            rst_start;

    rrs_row_timer #(.ROW_CLKS(ROW_CLKS)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_tick (row_tick)
    );

    rrs_integ_ctrl #(.FL_W(FL_W), .INTEG_RST(INTEG_RST)) integ_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_integ   (cfg_integ),
        .frame_len   (frame_len),
        .win_rows    (win_rows),
        .adopt       (adopt),
        .first_adopt (state_q == SEQ_IDLE),
        .integ_act   (integ_act)
    );

    always_comb begin
        win_rows  = {1'b0, win_last} - {1'b0, win_first} + FL_W'(1);
        slot_last = (rd_slot_q == frame_len - FL_W'(1));
        next_slot = slot_last ? '0 : rd_slot_q + FL_W'(1);
        adopt     = row_tick && ((state_q == SEQ_IDLE) || slot_last);
        rst_start = (state_q != SEQ_IDLE) && !slot_last &&
                    (next_slot == frame_len - integ_act);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (row_tick) state_d = SEQ_PRIME;
            SEQ_PRIME:  if (row_tick && slot_last) state_d = SEQ_STREAM;
            SEQ_STREAM: state_d = SEQ_STREAM;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // row pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_slot_q  <= '0;
            rst_idx_q  <= '0;
            rst_busy_q <= 1'b0;
        end else if (row_tick) begin
            if (state_q == SEQ_IDLE) begin
                rd_slot_q  <= '0;
                rst_busy_q <= 1'b0;
            end else begin
                rd_slot_q <= next_slot;
                if (rst_start) begin
                    rst_busy_q <= 1'b1;
                    rst_idx_q  <= '0;
                end else if (rst_busy_q) begin
                    if (rst_idx_q == win_rows - FL_W'(1)) rst_busy_q <= 1'b0;
                    else                                    rst_idx_q  <= rst_idx_q + FL_W'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        rd_vld      = (state_q == SEQ_STREAM) && (rd_slot_q < win_rows);
        rd_row      = win_first + rd_slot_q[ROW_W-1:0];
        rst_vld     = rst_busy_q;
        rst_row     = win_first + rst_idx_q[ROW_W-1:0];
        frame_start = (state_q == SEQ_STREAM) && (rd_slot_q == '0);
    end
endmodule

// File: rtl/rolling_row_seq_chk.sv
`timescale 1ns/1ps
module rolling_row_seq_chk #(
    parameter int ROW_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ROW_W-1:0] win_first,
    input logic [ROW_W-1:0] win_last,
    input logic [ROW_W-1:0] rst_row,
    input logic             rst_vld,
    input logic [ROW_W-1:0] rd_row,
    input logic             rd_vld,
    input logic             frame_start
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!rd_vld && !rst_vld && !frame_start));

    assert_read_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> (rd_row >= win_first && rd_row <= win_last));

    assert_read_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && $past(rd_vld) && rd_row != $past(rd_row) && !frame_start)
        |-> (rd_row == $past(rd_row) + ROW_W'(1)));

    assert_frame_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (rd_vld && rd_row == win_first));

    assert_reset_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_vld |-> (rst_row >= win_first && rst_row <= win_last));

    assert_reset_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_vld && $past(rst_vld) && rst_row != $past(rst_row) && rst_row != win_first)
        |-> (rst_row == $past(rst_row) + ROW_W'(1)));

    assert_no_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_vld && rd_vld && rst_row == rd_row));
endmodule

bind rolling_row_seq rolling_row_seq_chk #(.ROW_W(ROW_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .win_first   (win_first),
    .win_last    (win_last),
    .rst_row     (rst_row),
    .rst_vld     (rst_vld),
    .rd_row      (rd_row),
    .rd_vld      (rd_vld),
    .frame_start (frame_start)
);

// File: tb/rolling_row_seq_tb_top.sv
`timescale 1ns/1ps
module rolling_row_seq_tb_top;
    localparam int ROW_W    = 11;
    localparam int ROW_CLKS = 3;

    typedef struct packed {
        int first;
        int last;
        int flen;
        int i0;
        int wslot;
        int i1;
        int frames;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{6, 15, 14, 5, -1, 0, 4},
        '{0,  7,  8, 3, -1, 0, 4},
        '{2,  5,  9, 20, -1, 0, 3},
        '{10, 12, 6, 0, -1, 0, 3},
        '{6, 15, 14, 5, 17, 7, 5},
        '{6, 15, 14, 2, 17, 13, 6}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [ROW_W-1:0] win_first = '0;
    logic [ROW_W-1:0] win_last = '0;
    logic [ROW_W:0]   frame_len = 12'd2;
    logic             cfg_wr = 1'b0;
    logic [ROW_W:0]   cfg_integ = '0;
    logic [ROW_W-1:0] rst_row;
    logic             rst_vld;
    logic [ROW_W-1:0] rd_row;
    logic             rd_vld;
    logic             frame_start;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rolling_row_seq #(.ROW_W(ROW_W), .ROW_CLKS(ROW_CLKS), .INTEG_RST(4)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_first   (win_first),
        .win_last    (win_last),
        .frame_len   (frame_len),
        .cfg_wr      (cfg_wr),
        .cfg_integ   (cfg_integ),
        .rst_row     (rst_row),
        .rst_vld     (rst_vld),
        .rd_row      (rd_row),
        .rd_vld      (rd_vld),
        .frame_start (frame_start)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int clampf(input int x, input int f);
        if (x < 1) return 1;
        if (x > f - 1) return f - 1;
        return x;
    endfunction

    task automatic run_case(input vec_t v, input string etag);
        int h;
        int shadow_m;
        int adopt_m [16];
        int last_rst [64];
        int tup;
        h = v.last - v.first + 1;
        foreach (last_rst[i]) last_rst[i] = -1000;
        @(negedge clk);
        rst_n     = 1'b0;
        win_first = ROW_W'(v.first);
        win_last  = ROW_W'(v.last);
        frame_len = (ROW_W+1)'(v.flen);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rst_vld && !rd_vld && !frame_start, "R1 idle", int'({rst_vld, rd_vld, frame_start}), 0);
        cfg_wr    = 1'b1;
        cfg_integ = (ROW_W+1)'(v.i0);
        shadow_m  = v.i0;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(!rst_vld && !rd_vld && !frame_start, "R1 idle", int'({rst_vld, rd_vld, frame_start}), 0);
        @(negedge clk);
        for (int g = 0; g < v.frames * v.flen; g++) begin
            int k;
            int s;
            bit rd_e;
            bit fs_e;
            bit rs_e;
            int rrow;
            k = g / v.flen;
            s = g % v.flen;
            if (s == 0) begin
                adopt_m[k] = clampf(shadow_m, v.flen);
                if (k > 0 && adopt_m[k] > adopt_m[k-1] + v.flen - h)
                    adopt_m[k] = adopt_m[k-1] + v.flen - h;
            end
            rd_e = (k >= 1) && (s < h);
            fs_e = (k >= 1) && (s == 0);
            rs_e = 1'b0;
            rrow = 0;
            for (int kk = k; kk >= k - 1 && kk >= 0; kk--) begin
                int st;
                st = kk * v.flen + v.flen - adopt_m[kk];
                if (g - st >= 0 && g - st < h) begin
                    rs_e = 1'b1;
                    rrow = v.first + g - st;
                end
            end
            if (k == 0) chk(rd_vld == 1'b0, "R1 priming read", int'(rd_vld), 0);
            else chk(rd_vld == rd_e, "R3 read valid", int'(rd_vld), int'(rd_e));
            if (rd_e) chk(int'(rd_row) == v.first + s, "R3 read row", int'(rd_row), v.first + s);
            chk(frame_start == fs_e, "R4 frame start", int'(frame_start), int'(fs_e));
            chk(rst_vld == rs_e, "R5 reset valid", int'(rst_vld), int'(rs_e));
            if (rs_e) chk(int'(rst_row) == rrow, "R5 reset row", int'(rst_row), rrow);
            if (rst_vld && rd_vld)
                chk(rst_row != rd_row, "R10 same row", int'(rst_row), -1);
            if (rst_vld && int'(rst_row) < 64) last_rst[int'(rst_row)] = g;
            if (rd_vld && k >= 1 && int'(rd_row) < 64)
                chk(g - last_rst[int'(rd_row)] == adopt_m[k-1], etag,
                    g - last_rst[int'(rd_row)], adopt_m[k-1]);
            tup = int'({rst_vld, rst_row, rd_vld, rd_row, frame_start});
            if (g == v.wslot) begin
                cfg_wr    = 1'b1;
                cfg_integ = (ROW_W+1)'(v.i1);
                shadow_m  = v.i1;
            end
            for (int c = 1; c < ROW_CLKS; c++) begin
                @(negedge clk);
                cfg_wr = 1'b0;
                chk(int'({rst_vld, rst_row, rd_vld, rd_row, frame_start}) == tup, "R2 hold",
                    int'({rst_vld, rst_row, rd_vld, rd_row, frame_start}), tup);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #12;
        // R1: quiet outputs during reset
        chk(!rd_vld, "R1 reset rd_vld", int'(rd_vld), 0);
        chk(!rst_vld, "R1 reset rst_vld", int'(rst_vld), 0);
        chk(!frame_start, "R1 reset frame_start", int'(frame_start), 0);
        for (int i = 0; i < NV; i++) begin
            string etag;
            case (i)
                2, 3:    etag = "R8 clamped exposure";
                4:       etag = "R7 deferred exposure";
                5:       etag = "R9 limited rise";
                default: etag = "R6 exposure";
            endcase
            run_case(VECS[i], etag);
        end
        // R1: reset asserted while streaming silences outputs at once
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(!rd_vld && !rst_vld && !frame_start, "R1 mid-stream reset",
            int'({rst_vld, rd_vld, frame_start}), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule